// File: doc/BRIEF.md
# Ping-pong receive buffer controller

This block is the receive back end of a small network interface. A byte stream carrying whole frames enters on the receive side. Each frame is packed into 32-bit words and written into one of two receive buffers. When the last byte of a frame has been stored, that buffer is marked done and stays owned by the host until the host releases it. While both buffers are owned by the host, a new frame is thrown away in full and counted.

The host sees both buffers and their status words through one memory-mapped window. It reads frame words and status words with a one-cycle read latency. It releases a buffer by writing its status word with the done bit clear. Each buffer has its own interrupt-enable bit. A one-cycle interrupt pulse marks each frame stored in a buffer whose enable bit is set.

The host polls the expected buffer first and then the other one. To match that, the block fills the buffers alternately, starting with buffer 0. If the expected buffer is still held, the block uses the other buffer when that one is free.

Top module: `rxpp_rx_ctrl`

## Requirements
- R1: After reset both status words read 0, `rx_irq` is 0, `drop_count` is 0, and the first accepted frame is stored in buffer 0.
- R2: Buffer b (0 or 1) occupies byte addresses `RX_BASE + b*WIN_BYTES` up to the next window. Its status word sits at window offset `WIN_BYTES-4`, which gives 0x17FC and 0x1FFC with the defaults. In a status word, bit 0 is done, bit 3 is interrupt enable, and every other bit reads 0. Any address outside the two windows reads 0. `host_rdata` shows the word addressed at the previous rising clock edge.
- R3: Frame byte k is stored big-endian, in the word at window offset `4*(k/4)`, bits `[31-8*(k%4) -: 8]`. The unused low bytes of a frame's last word read 0.
- R4: When the host releases each buffer before the next frame starts, consecutive frames go to buffer 0, 1, 0, 1, ... and set done in that buffer only.
- R5: If the expected buffer still has done set when a frame starts and the other buffer is free, the frame goes to the other buffer. The next expected buffer is then the one opposite the buffer just used.
- R6: If both buffers have done set when a frame starts, every byte of that frame is discarded, neither buffer changes, and `drop_count` increases by one.
- R7: A host write to a status word with bit 0 clear clears done and frees the buffer. A write with bit 0 set never sets done.
- R8: A host write to a status word stores bit 3 as that buffer's interrupt enable, and reads return it.
- R9: `rx_irq` is high for exactly the one cycle after the edge that accepts a frame's last byte, and only if the receiving buffer's interrupt enable is set. Dropped and ignored frames never raise it.
- R10: A frame whose first byte arrives while `rx_enable` is low is ignored in full. No buffer, status bit, expected-buffer choice or drop count changes.
- R11: Bytes beyond the first `WIN_BYTES-4` bytes of a frame are not stored, and the frame still sets done when it ends.
- R12: Host writes to frame-data addresses have no effect on the stored words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_enable | input | 1 | Accept frames; sampled at each frame's first byte |
| rx_valid | input | 1 | A frame byte is present on `rx_data` |
| rx_data | input | 8 | Frame byte |
| rx_last | input | 1 | Marks the last byte of the frame |
| host_addr | input | ADDR_W | Host byte address |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read data for the address presented one edge earlier |
| rx_irq | output | 1 | One-cycle frame-stored interrupt pulse |
| drop_count | output | DROP_W | Wrapping count of frames dropped because both buffers were held |

## Verification
The bench builds the block with a 64-byte window, so each buffer holds 60 frame bytes in 15 words. This small size lets one sweep try every frame length from 1 to 62 bytes: every last-word fill level, the exact-capacity frame, and frames that run past capacity. The sweep reads back every stored word, and it checks the buffer alternation and the interrupt enable on each frame. Directed sequences with the buffers held then cover the fallback to the other buffer, whole-frame drops, ignored frames, and host writes that must not set done or change frame data.

// File: rtl/rxpp_pkg.sv
`timescale 1ns/1ps
package rxpp_pkg;

    // Kind of word captured for the host read path
    typedef enum logic [1:0] {
        RD_NONE = 2'd0,
        RD_DATA = 2'd1,
        RD_STAT = 2'd2
    } rd_kind_e;

    // Status word bit positions seen by the host
    localparam int STAT_DONE_BIT = 0;
    localparam int STAT_IE_BIT   = 3;

    // Place a byte into a word, lane 0 being the most significant byte
    function automatic logic [31:0] lane_insert(input logic [31:0] word,
                                                input logic [1:0]  lane,
                                                input logic [7:0]  value);
        logic [31:0] r;
        r = word;
        case (lane)
            2'd0:    r[31:24] = value;
            2'd1:    r[23:16] = value;
            2'd2:    r[15:8]  = value;
            default: r[7:0]   = value;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/rxpp_ingest.sv
`timescale 1ns/1ps
module rxpp_ingest
    import rxpp_pkg::*;
#(
    parameter int CAP_BYTES = 2044,
    parameter int WORD_AW   = 9,
    parameter int DROP_W    = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rx_enable,
    input  logic               rx_valid,
    input  logic [7:0]         rx_data,
    input  logic               rx_last,
    input  logic [1:0]         done_i,
    output logic               wr_en_o,
    output logic               wr_bank_o,
    output logic [WORD_AW-1:0] wr_word_o,
    output logic [31:0]        wr_data_o,
    output logic [1:0]         done_set_o,
    output logic [DROP_W-1:0]  drop_cnt_o
);

    localparam int CNT_W = $clog2(CAP_BYTES + 1);

    typedef struct packed {
        logic              busy;     // inside a frame
        logic              discard;  // current frame is being thrown away
        logic              bank;     // buffer receiving the current frame
        logic              nxt;      // buffer the host expects next
        logic [CNT_W-1:0]  cnt;      // bytes stored so far
        logic [31:0]       acc;      // partially packed word
        logic [DROP_W-1:0] drops;
    } ing_t;

    ing_t        ing_q, ing_d;
    logic        pick;
    logic        both_held;
    logic [31:0] packed_w;

    always_comb begin
        ing_d      = ing_q;
        wr_en_o    = 1'b0;
        wr_bank_o  = ing_q.bank;
        wr_word_o  = '0;
        wr_data_o  = '0;
        done_set_o = '0;
        packed_w   = '0;
        pick       = ing_q.nxt;
        both_held  = 1'b0;

        // Expected buffer first, the other one as fallback
        if (!done_i[ing_q.nxt]) begin
            pick = ing_q.nxt;
        end else if (!done_i[~ing_q.nxt]) begin
            pick = ~ing_q.nxt;
        end else begin
            both_held = 1'b1;
        end

        if (rx_valid) begin
            if (!ing_q.busy) begin
                ing_d.bank    = pick;
                ing_d.discard = !rx_enable || both_held;
                ing_d.cnt     = '0;
                ing_d.acc     = '0;
                if (rx_enable && both_held) begin
                    ing_d.drops = ing_q.drops + 1'b1;
                end
            end

            if (!ing_d.discard) begin
                if (ing_d.cnt < CNT_W'(CAP_BYTES)) begin
                    packed_w  = lane_insert(ing_d.acc, ing_d.cnt[1:0], rx_data);
                    wr_en_o   = (ing_d.cnt[1:0] == 2'd3) || rx_last;
                    wr_bank_o = ing_d.bank;
                    wr_word_o = WORD_AW'(ing_d.cnt >> 2);
                    wr_data_o = packed_w;
                    ing_d.acc = (ing_d.cnt[1:0] == 2'd3) ? 32'd0 : packed_w;
                    ing_d.cnt = ing_d.cnt + 1'b1;
                end
                if (rx_last) begin
                    done_set_o[ing_d.bank] = 1'b1;
                    ing_d.nxt              = ~ing_d.bank;
                end
            end

            ing_d.busy = !rx_last;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ing_q <= '0;
        end else begin
            ing_q <= ing_d;
        end
    end

    assign drop_cnt_o = ing_q.drops;

    // Frame words only ever land in a buffer the host has released
    assert_store_free_bank_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> !done_i[wr_bank_o])
        else $error("word written into a buffer still held by the host");

    // The drop count moves only when both buffers were held
    assert_drop_when_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ing_q.drops != $past(ing_q.drops)) |-> ($past(done_i) == 2'b11))
        else $error("drop counted while a buffer was free");

    // Stored byte count never passes the buffer capacity
    assert_cnt_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ing_q.cnt <= CNT_W'(CAP_BYTES))
        else $error("byte count past buffer capacity");

endmodule

// File: rtl/rxpp_status.sv
`timescale 1ns/1ps
module rxpp_status (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] done_set_i,
    input  logic       hw_en_i,
    input  logic       hw_bank_i,
    input  logic       hw_done_i,
    input  logic       hw_ie_i,
    output logic [1:0] done_o,
    output logic [1:0] ie_o,
    output logic       irq_o
);

    typedef struct packed {
        logic [1:0] done;
        logic [1:0] ie;
        logic       irq;
    } stat_t;

    stat_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (hw_en_i) begin
            if (!hw_done_i) begin
                st_d.done[hw_bank_i] = 1'b0;
            end
            st_d.ie[hw_bank_i] = hw_ie_i;
        end
        // A stored frame wins over a host clear in the same cycle
        st_d.done = st_d.done | done_set_i;
        st_d.irq  = |(done_set_i & st_q.ie);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign done_o = st_q.done;
    assign ie_o   = st_q.ie;
    assign irq_o  = st_q.irq;

    // An interrupt pulse always coincides with a newly set done bit
    assert_irq_new_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ((st_q.done & ~$past(st_q.done)) != 2'b00))
        else $error("interrupt without a newly stored frame");

    for (genvar b = 0; b < 2; b++) begin : g_chk
        // Done rises only when the ingest side finished a frame
        assert_done_from_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(st_q.done[b]) |-> $past(done_set_i[b]))
            else $error("done set without a finished frame");
    end

endmodule

// File: rtl/rxpp_bank_mem.sv
`timescale 1ns/1ps
module rxpp_bank_mem #(
    parameter int WORD_AW = 9
) (
    input  logic               clk,
    input  logic               wr_en_i,
    input  logic               wr_bank_i,
    input  logic [WORD_AW-1:0] wr_word_i,
    input  logic [31:0]        wr_data_i,
    input  logic [WORD_AW-1:0] rd_word_i,
    output logic [1:0][31:0]   rd_data_o
);

    localparam int DEPTH = 1 << WORD_AW;

    for (genvar b = 0; b < 2; b++) begin : g_bank
        logic [31:0] store [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_en_i && (wr_bank_i == 1'(b))) begin
                store[wr_word_i] <= wr_data_i;
            end
            rd_data_o[b] <= store[rd_word_i];
        end
    end

endmodule

// File: rtl/rxpp_rx_ctrl.sv
`timescale 1ns/1ps
module rxpp_rx_ctrl
    import rxpp_pkg::*;
#(
    parameter int RX_BASE   = 32'h1000,
    parameter int WIN_BYTES = 2048,
    parameter int ADDR_W    = 13,
    parameter int DROP_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_enable,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    input  logic              rx_last,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_wr,
    input  logic [31:0]       host_wdata,
    output logic [31:0]       host_rdata,
    output logic              rx_irq,
    output logic [DROP_W-1:0] drop_count
);

    localparam int WIN_LOG   = $clog2(WIN_BYTES);
    localparam int CAP_BYTES = WIN_BYTES - 4;
    localparam int CAP_WORDS = CAP_BYTES / 4;
    localparam int WORD_AW   = $clog2(CAP_WORDS);
    localparam int HI_W      = ADDR_W - WIN_LOG - 1;
    localparam int RX_TAG    = RX_BASE >> (WIN_LOG + 1);

    typedef struct packed {
        rd_kind_e   kind;
        logic       bank;
        logic [3:0] stat;
    } rd_t;

    rd_t                rd_q, rd_d;

    logic               wr_en;
    logic               wr_bank;
    logic [WORD_AW-1:0] wr_word;
    logic [31:0]        wr_data;
    logic [1:0]         done_set;
    logic [1:0]         done;
    logic [1:0]         ie;
    logic [1:0][31:0]   mem_rd;

    logic               in_rx;
    logic               a_bank;
    logic [WIN_LOG-1:0] a_off;
    logic               is_stat;
    logic               is_data;
    logic [WORD_AW-1:0] a_word;

    // Host address decode
    always_comb begin
        in_rx   = (host_addr[ADDR_W-1:WIN_LOG+1] == HI_W'(RX_TAG));
        a_bank  = host_addr[WIN_LOG];
        a_off   = host_addr[WIN_LOG-1:0];
        is_stat = in_rx && (a_off == WIN_LOG'(WIN_BYTES - 4));
        is_data = in_rx && (a_off < WIN_LOG'(CAP_BYTES));
        a_word  = WORD_AW'(a_off >> 2);
    end

    rxpp_ingest #(
        .CAP_BYTES (CAP_BYTES),
        .WORD_AW   (WORD_AW),
        .DROP_W    (DROP_W)
    ) u_ingest (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_enable  (rx_enable),
        .rx_valid   (rx_valid),
        .rx_data    (rx_data),
        .rx_last    (rx_last),
        .done_i     (done),
        .wr_en_o    (wr_en),
        .wr_bank_o  (wr_bank),
        .wr_word_o  (wr_word),
        .wr_data_o  (wr_data),
        .done_set_o (done_set),
        .drop_cnt_o (drop_count)
    );

    rxpp_status u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .done_set_i (done_set),
        .hw_en_i    (host_wr && is_stat),
        .hw_bank_i  (a_bank),
        .hw_done_i  (host_wdata[STAT_DONE_BIT]),
        .hw_ie_i    (host_wdata[STAT_IE_BIT]),
        .done_o     (done),
        .ie_o       (ie),
        .irq_o      (rx_irq)
    );

    rxpp_bank_mem #(
        .WORD_AW (WORD_AW)
    ) u_mem (
        .clk       (clk),
        .wr_en_i   (wr_en),
        .wr_bank_i (wr_bank),
        .wr_word_i (wr_word),
        .wr_data_i (wr_data),
        .rd_word_i (a_word),
        .rd_data_o (mem_rd)
    );

    // Read path: capture what was addressed, answer one edge later
    always_comb begin
        rd_d      = rd_q;
        rd_d.bank = a_bank;
        rd_d.stat = {ie[a_bank], 2'b00, done[a_bank]};
        if (is_stat) begin
            rd_d.kind = RD_STAT;
        end else if (is_data) begin
            rd_d.kind = RD_DATA;
        end else begin
            rd_d.kind = RD_NONE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '{kind: RD_NONE, bank: 1'b0, stat: 4'd0};
        end else begin
            rd_q <= rd_d;
        end
    end

    always_comb begin
        case (rd_q.kind)
            RD_DATA: host_rdata = mem_rd[rd_q.bank];
            RD_STAT: host_rdata = {28'd0, rd_q.stat};
            default: host_rdata = 32'd0;
        endcase
    end

endmodule

// File: tb/rxpp_rx_ctrl_test.sv
`timescale 1ns/1ps
module rxpp_rx_ctrl_test;

    localparam int RX_BASE = 32'h1000;
    localparam int WIN     = 64;
    localparam int CAP     = WIN - 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_enable = 1'b1;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_last = 1'b0;
    logic [12:0] host_addr = '0;
    logic        host_wr = 1'b0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        rx_irq;
    logic [7:0]  drop_count;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    rxpp_rx_ctrl #(
        .RX_BASE   (RX_BASE),
        .WIN_BYTES (WIN),
        .ADDR_W    (13),
        .DROP_W    (8)
    ) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_enable  (rx_enable),
        .rx_valid   (rx_valid),
        .rx_data    (rx_data),
        .rx_last    (rx_last),
        .host_addr  (host_addr),
        .host_wr    (host_wr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .rx_irq     (rx_irq),
        .drop_count (drop_count)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int seed, input int k);
        return 8'(seed * 13 + k * 7 + 1);
    endfunction

    function automatic logic [31:0] exp_word(input int seed, input int len, input int w);
        logic [31:0] r;
        int stored;
        stored = (len < CAP) ? len : CAP;
        r = '0;
        for (int j = 0; j < 4; j++) begin
            r = {r[23:0], ((4 * w + j) < stored) ? pat(seed, 4 * w + j) : 8'h00};
        end
        return r;
    endfunction

    function automatic logic [12:0] stat_addr(input int b);
        return 13'(RX_BASE + b * WIN + CAP);
    endfunction

    function automatic logic [12:0] data_addr(input int b, input int w);
        return 13'(RX_BASE + b * WIN + 4 * w);
    endfunction

    task automatic host_read(input logic [12:0] a, output logic [31:0] d);
        @(negedge clk);
        host_addr = a;
        @(negedge clk);
        d = host_rdata;
    endtask

    task automatic host_write(input logic [12:0] a, input logic [31:0] d);
        @(negedge clk);
        host_addr  = a;
        host_wdata = d;
        host_wr    = 1'b1;
        @(negedge clk);
        host_wr    = 1'b0;
    endtask

    // Ends on the negedge after the edge that accepted the last byte
    task automatic send_frame(input int len, input int seed);
        for (int k = 0; k < len; k++) begin
            @(negedge clk);
            rx_valid = 1'b1;
            rx_data  = pat(seed, k);
            rx_last  = (k == len - 1);
        end
        @(negedge clk);
        rx_valid = 1'b0;
        rx_last  = 1'b0;
    endtask

    task automatic frame_irq(input string req, input logic exp);
        chk(req, {31'd0, rx_irq}, {31'd0, exp});
        @(negedge clk);
        chk("R9 pulse width", {31'd0, rx_irq}, 32'd0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        logic [31:0] rd;
        int eb;
        int stored;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        host_read(stat_addr(0), rd); chk("R1 status0", rd, 32'h0);
        host_read(stat_addr(1), rd); chk("R1 status1", rd, 32'h0);
        chk("R1 irq", {31'd0, rx_irq}, 32'd0);
        chk("R1 drops", {24'd0, drop_count}, 32'd0);
        // R2 outside the windows
        host_read(13'h0FFC, rd); chk("R2 outside", rd, 32'h0);

        // R8 interrupt enable on buffer 0 only
        host_write(stat_addr(0), 32'h8);
        host_read(stat_addr(0), rd); chk("R8 ie readback", rd, 32'h8);

        // Sweep every frame length, buffers alternate
        eb = 0;
        for (int len = 1; len <= 62; len++) begin
            send_frame(len, len);
            frame_irq("R9 irq", eb == 0);
            host_read(stat_addr(eb), rd);
            chk("R4 done in expected buffer", rd, (eb == 0) ? 32'h9 : 32'h1);
            host_read(stat_addr(1 - eb), rd);
            chk("R4 other buffer free", rd, (eb == 1) ? 32'h8 : 32'h0);
            stored = (len < CAP) ? len : CAP;
            for (int w = 0; w < (stored + 3) / 4; w++) begin
                host_read(data_addr(eb, w), rd);
                if (len > CAP) chk("R11 truncated data", rd, exp_word(len, len, w));
                else           chk("R3 packed data", rd, exp_word(len, len, w));
            end
            host_write(stat_addr(eb), (eb == 0) ? 32'h8 : 32'h0);
            host_read(stat_addr(eb), rd);
            chk("R7 release", rd, (eb == 0) ? 32'h8 : 32'h0);
            eb = 1 - eb;
        end

        // Fill both buffers, then drop (expected buffer is 0 here)
        send_frame(8, 100); frame_irq("R9 irq A", 1'b1);
        send_frame(8, 101); frame_irq("R9 irq B", 1'b0);
        send_frame(8, 102); frame_irq("R9 dropped no irq", 1'b0);
        chk("R6 drop count", {24'd0, drop_count}, 32'd1);
        host_read(data_addr(0, 0), rd); chk("R6 buffer0 kept", rd, exp_word(100, 8, 0));
        host_read(data_addr(1, 1), rd); chk("R6 buffer1 kept", rd, exp_word(101, 8, 1));

        // Fallback: expected buffer 0 held, buffer 1 freed
        host_write(stat_addr(1), 32'h0);
        send_frame(5, 103); frame_irq("R9 irq D", 1'b0);
        host_read(stat_addr(1), rd); chk("R5 fallback done", rd, 32'h1);
        host_read(data_addr(1, 1), rd); chk("R5 fallback data", rd, exp_word(103, 5, 1));
        host_write(stat_addr(0), 32'h8);
        send_frame(6, 104); frame_irq("R9 irq E", 1'b1);
        host_read(stat_addr(0), rd); chk("R5 expected after fallback", rd, 32'h9);
        host_read(data_addr(0, 0), rd); chk("R5 data E", rd, exp_word(104, 6, 0));
        host_write(stat_addr(0), 32'h8);
        host_write(stat_addr(1), 32'h0);

        // R7 host cannot set done
        host_write(stat_addr(1), 32'h1);
        host_read(stat_addr(1), rd); chk("R7 no host set", rd, 32'h0);
        host_write(stat_addr(0), 32'h9);
        host_read(stat_addr(0), rd); chk("R7 no host set ie kept", rd, 32'h8);

        // R12 data words are read-only to the host
        host_write(data_addr(0, 0), 32'hDEADBEEF);
        host_read(data_addr(0, 0), rd); chk("R12 data unchanged", rd, exp_word(104, 6, 0));

        // R10 disabled frame is ignored; expected buffer is now 1
        rx_enable = 1'b0;
        send_frame(7, 105); frame_irq("R10 no irq", 1'b0);
        rx_enable = 1'b1;
        host_read(stat_addr(0), rd); chk("R10 status0", rd, 32'h8);
        host_read(stat_addr(1), rd); chk("R10 status1", rd, 32'h0);
        chk("R10 drops", {24'd0, drop_count}, 32'd1);
        send_frame(4, 106); frame_irq("R9 irq G", 1'b0);
        host_read(stat_addr(1), rd); chk("R10 pointer kept", rd, 32'h1);
        host_read(data_addr(1, 0), rd); chk("R3 data G", rd, exp_word(106, 4, 0));

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule